// File: doc/BRIEF.md
# I/O Instruction Condition Code Responder

This block decides how a channel answers three processor I/O instructions: test-I/O, halt-I/O and test-channel. Each instruction arrives as a one-cycle pulse with a unit address. The block reads the channel, subchannel and interface state presented on its inputs. It then either releases the processor at once with a two-bit condition code, or hands a selection request to an external selection sequencer and waits for that sequencer to report how the device replied. Some outcomes must be recorded. In those cases the block raises a store-status request together with a 16-bit status word, made of a device byte in the upper half and a channel byte in the lower half. It also drives the tag controls that halt needs: raise address-out, drop select-out and disconnect.

The block holds one pending-interrupt record, made of a flag, a unit address and a device status byte. An external source can load this record. The block also loads the record itself when a halt leaves an interrupt outstanding. A test-I/O whose unit address matches the record stores the recorded status, and the record is cleared on the same clock edge that registers the release strobe. Every result is registered, so the release appears one cycle after the edge that accepted the instruction, or one cycle after the edge that sampled the sequencer's reply. Instructions arriving while the block is busy are dropped.

Top module: `io_cc_responder`

## Requirements
- R1: A test-I/O (instKind=0) whose unitAddr equals the address of a valid pending record releases with code 01. It raises storeReq with storeStatus = {recorded device byte, chanStatIn}. It clears the record, so a later test-channel no longer reports 01.
- R2: A test-I/O with no pending match, on an operational channel whose subchannel is working or in burst mode, releases with code 10 and starts no selection.
- R3: A test-I/O to an available, idle subchannel pulses selStart with selStatusOnly=1 and holds busy high. On selDone, selResp (0 operational-in, 1 control-unit-busy, 2 or 3 select-in) is resolved as follows. Select-in gives 11. Any other reply with nonzero devStatus gives 01 and stores {devStatus, chanStatIn}. Any other reply with zero devStatus gives 00 and stores nothing.
- R4: A halt-I/O (instKind=1) to a selector subchannel with an end interrupt outstanding returns 00. A halt-I/O to a multiplex subchannel that is not in burst mode and not available returns 00. A halt-I/O to a selector subchannel that is neither working nor available returns 00.
- R5: A halt-I/O to a working selector subchannel pulses addrOutRaise, selOutDrop and intReqSet together with a release carrying code 10, and loads the pending record with the halted address.
- R6: A halt-I/O to a multiplex subchannel in burst mode releases with code 10, addrOutRaise and selOutDrop, but without intReqSet. intReqSet pulses one cycle after statusAccepted is sampled, and busy stays high until then.
- R7: A halt-I/O to an available subchannel pulses selStart with selStatusOnly=0. An operational-in reply gives disconnectReq and a stored all-zero status with code 01. A control-unit-busy reply stores {devStatus, 8'h00} with code 01. A select-in reply gives code 11.
- R8: Test-channel (instKind=2) ignores unitAddr. Its code is chosen in this order: 11 if the channel is not operational, then 00 if any interface is available, then 01 if the pending record is valid, then 10 if all interfaces are in burst mode, otherwise 11.
- R9: Test-I/O and halt-I/O on a channel that is not operational return 11.
- R10: An instruction pulse that arrives while busy is high produces no release and is not queued. instKind=3 produces no release.
- R11: After reset, all strobes are low, busy is low and the pending record is empty.
- R12: A release decided without selection appears exactly one cycle after the instruction is sampled. A release after selection appears exactly one cycle after selDone is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Instruction pulse |
| instKind | input | 2 | 0 test-I/O, 1 halt-I/O, 2 test-channel, 3 none |
| unitAddr | input | ADDR_W | Unit address of the instruction |
| pendSet | input | 1 | Load the pending-interrupt record |
| pendSetAddr | input | ADDR_W | Address for the loaded record |
| pendSetStatus | input | STAT_W | Device status for the loaded record |
| chanOper | input | 1 | Channel is operational |
| subAvail | input | 1 | Addressed subchannel is available |
| subWorking | input | 1 | Addressed subchannel is executing a command |
| subBurst | input | 1 | Addressed subchannel's interface is in burst mode |
| subIsSelector | input | 1 | Addressed subchannel is a selector type (0 is multiplex) |
| endIntOut | input | 1 | End interrupt outstanding on the selector subchannel |
| anyIfAvail | input | 1 | At least one interface is available |
| allIfBurst | input | 1 | All interfaces are in burst mode |
| selDone | input | 1 | Selection sequencer has a reply |
| selResp | input | 2 | Reply kind: 0 operational-in, 1 control-unit-busy, 2/3 select-in |
| devStatus | input | STAT_W | Device status byte from selection |
| chanStatIn | input | STAT_W | Channel status byte for test-I/O stores |
| statusAccepted | input | 1 | Halted burst device's status was accepted |
| busy | output | 1 | Waiting on selection or on halted status |
| ccValid | output | 1 | Release strobe |
| ccCode | output | 2 | Condition code, valid with ccValid |
| storeReq | output | 1 | Store-status request |
| storeStatus | output | 2*STAT_W | {device byte, channel byte} to store |
| intReqSet | output | 1 | Set interrupt request |
| addrOutRaise | output | 1 | Raise address-out |
| selOutDrop | output | 1 | Drop select-out |
| disconnectReq | output | 1 | Perform the interface-disconnect sequence |
| selStart | output | 1 | Start device selection |
| selStatusOnly | output | 1 | Selection carries the status-only command (1) or is a halt (0) |

## Verification
The hardest situations to reach are the multi-step outcomes. One is the deferred interrupt after a burst-mode halt. Another is the pending record, which a working-selector halt creates and which only an address-matched test-I/O clears. The bench reaches the pending record by running a working-selector halt as the last entry of its vector table. It then checks that test-channel reports 01 with interfaces busy, that a test-I/O to a different address is not matched, and that a test-I/O to the halted address stores the record and drops the 01 answer. For the burst halt, it holds statusAccepted low for several cycles before pulsing it, and it injects an instruction while the selection wait is open.

// File: rtl/io_cc_pkg.sv
package io_cc_pkg;

  typedef enum logic [1:0] {
    INST_TIO  = 2'd0,
    INST_HIO  = 2'd1,
    INST_TCH  = 2'd2,
    INST_NONE = 2'd3
  } instKindE;

  typedef enum logic [1:0] {
    RESP_OPIN   = 2'd0,
    RESP_CUBUSY = 2'd1,
    RESP_SELIN  = 2'd2,
    RESP_RSV    = 2'd3
  } respE;

  typedef enum logic [1:0] {
    SRC_PEND     = 2'd0,
    SRC_DEV_CHAN = 2'd1,
    SRC_DEV_ONLY = 2'd2,
    SRC_ZERO     = 2'd3
  } storeSrcE;

  typedef enum logic [1:0] {
    CC_OK     = 2'd0,
    CC_STORED = 2'd1,
    CC_BUSY   = 2'd2,
    CC_NOTOP  = 2'd3
  } ccE;

  typedef struct packed {
    logic     relStb;
    ccE       cc;
    logic     store;
    storeSrcE storeSrc;
    logic     setInt;
    logic     addrOut;
    logic     selDrop;
    logic     disconnect;
    logic     selStart;
    logic     statusOnly;
    logic     clearPend;
    logic     latchAddr;
  } strobeT;

endpackage

// File: rtl/io_cc_ctrl.sv
module io_cc_ctrl
  import io_cc_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [1:0]        instKind,
  input  logic              chanOper,
  input  logic              subAvail,
  input  logic              subWorking,
  input  logic              subBurst,
  input  logic              subIsSelector,
  input  logic              endIntOut,
  input  logic              anyIfAvail,
  input  logic              allIfBurst,
  input  logic              selDone,
  input  logic [1:0]        selResp,
  input  logic [STAT_W-1:0] devStatus,
  input  logic              statusAccepted,
  input  logic              pendValid,
  input  logic              pendMatch,
  output strobeT            st,
  output logic              busy
);

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_HWAIT} stateE;

  stateE    state, stateNxt;
  instKindE kindQ, kindNxt;
  logic     devNz;

  assign devNz = |devStatus;
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= INST_NONE;
    end else begin
      state <= stateNxt;
      kindQ <= kindNxt;
    end
  end

  always_comb begin
    st       = '0;
    stateNxt = state;
    kindNxt  = kindQ;
    unique case (state)
      S_IDLE: begin
        if (instValid) begin
          st.latchAddr = 1'b1;
          kindNxt      = instKindE'(instKind);
          unique case (instKindE'(instKind))
            INST_TCH: begin
              st.relStb = 1'b1;
              if (!chanOper)       st.cc = CC_NOTOP;
              else if (anyIfAvail) st.cc = CC_OK;
              else if (pendValid)  st.cc = CC_STORED;
              else if (allIfBurst) st.cc = CC_BUSY;
              else                 st.cc = CC_NOTOP;
            end
            INST_TIO: begin
              if (!chanOper) begin
                st.relStb = 1'b1;
                st.cc     = CC_NOTOP;
              end else if (pendMatch) begin
                st.relStb    = 1'b1;
                st.cc        = CC_STORED;
                st.store     = 1'b1;
                st.storeSrc  = SRC_PEND;
                st.clearPend = 1'b1;
              end else if (subWorking || subBurst) begin
                st.relStb = 1'b1;
                st.cc     = CC_BUSY;
              end else if (subAvail) begin
                st.selStart   = 1'b1;
                st.statusOnly = 1'b1;
                stateNxt      = S_SEL;
              end else begin
                st.relStb = 1'b1;
                st.cc     = CC_NOTOP;
              end
            end
            INST_HIO: begin
              if (!chanOper) begin
                st.relStb = 1'b1;
                st.cc     = CC_NOTOP;
              end else if (subIsSelector && endIntOut) begin
                st.relStb = 1'b1;
                st.cc     = CC_OK;
              end else if (subIsSelector && subWorking) begin
                st.relStb  = 1'b1;
                st.cc      = CC_BUSY;
                st.addrOut = 1'b1;
                st.selDrop = 1'b1;
                st.setInt  = 1'b1;
              end else if (!subIsSelector && subBurst) begin
                st.relStb  = 1'b1;
                st.cc      = CC_BUSY;
                st.addrOut = 1'b1;
                st.selDrop = 1'b1;
                stateNxt   = S_HWAIT;
              end else if (subAvail) begin
                st.selStart = 1'b1;
                stateNxt    = S_SEL;
              end else begin
                st.relStb = 1'b1;
                st.cc     = CC_OK;
              end
            end
            default: ;
          endcase
        end
      end
      S_SEL: begin
        if (selDone) begin
          stateNxt  = S_IDLE;
          st.relStb = 1'b1;
          if (respE'(selResp) == RESP_SELIN || respE'(selResp) == RESP_RSV) begin
            st.cc = CC_NOTOP;
          end else if (kindQ == INST_TIO) begin
            if (devNz) begin
              st.cc       = CC_STORED;
              st.store    = 1'b1;
              st.storeSrc = SRC_DEV_CHAN;
            end else begin
              st.cc = CC_OK;
            end
          end else if (respE'(selResp) == RESP_OPIN) begin
            st.cc         = CC_STORED;
            st.store      = 1'b1;
            st.storeSrc   = SRC_ZERO;
            st.disconnect = 1'b1;
          end else begin
            st.cc       = CC_STORED;
            st.store    = 1'b1;
            st.storeSrc = SRC_DEV_ONLY;
          end
        end
      end
      S_HWAIT: begin
        if (statusAccepted) begin
          st.setInt = 1'b1;
          stateNxt  = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  // R10
  sel_wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SEL && !selDone) |=> (state == S_SEL));

  // R6
  halt_wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HWAIT && !statusAccepted) |=> (state == S_HWAIT && busy));

endmodule

// File: rtl/io_cc_datapath.sv
module io_cc_datapath
  import io_cc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              st,
  input  logic [ADDR_W-1:0]   unitAddr,
  input  logic                pendSet,
  input  logic [ADDR_W-1:0]   pendSetAddr,
  input  logic [STAT_W-1:0]   pendSetStatus,
  input  logic [STAT_W-1:0]   devStatus,
  input  logic [STAT_W-1:0]   chanStatIn,
  output logic                pendValid,
  output logic                pendMatch,
  output logic                ccValid,
  output logic [1:0]          ccCode,
  output logic                storeReq,
  output logic [2*STAT_W-1:0] storeStatus,
  output logic                intReqSet,
  output logic                addrOutRaise,
  output logic                selOutDrop,
  output logic                disconnectReq,
  output logic                selStart,
  output logic                selStatusOnly
);

  localparam int WORD_W = 2 * STAT_W;

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] pendAddr;
  logic [STAT_W-1:0] pendStatus;
  logic [ADDR_W-1:0] intAddr;
  logic [WORD_W-1:0] storeWord;

  assign pendMatch = pendValid && (pendAddr == unitAddr);
  assign intAddr   = st.latchAddr ? unitAddr : curAddr;

  always_comb begin
    unique case (st.storeSrc)
      SRC_PEND:     storeWord = {pendStatus, chanStatIn};
      SRC_DEV_CHAN: storeWord = {devStatus, chanStatIn};
      SRC_DEV_ONLY: storeWord = {devStatus, {STAT_W{1'b0}}};
      default:      storeWord = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
    end else if (st.latchAddr) begin
      curAddr <= unitAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid  <= 1'b0;
      pendAddr   <= '0;
      pendStatus <= '0;
    end else if (st.setInt) begin
      pendValid  <= 1'b1;
      pendAddr   <= intAddr;
      pendStatus <= '0;
    end else if (pendSet) begin
      pendValid  <= 1'b1;
      pendAddr   <= pendSetAddr;
      pendStatus <= pendSetStatus;
    end else if (st.clearPend) begin
      pendValid  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccValid       <= 1'b0;
      ccCode        <= 2'b00;
      storeReq      <= 1'b0;
      storeStatus   <= '0;
      intReqSet     <= 1'b0;
      addrOutRaise  <= 1'b0;
      selOutDrop    <= 1'b0;
      disconnectReq <= 1'b0;
      selStart      <= 1'b0;
      selStatusOnly <= 1'b0;
    end else begin
      ccValid       <= st.relStb;
      ccCode        <= st.relStb ? st.cc : 2'b00;
      storeReq      <= st.store;
      storeStatus   <= st.store ? storeWord : '0;
      intReqSet     <= st.setInt;
      addrOutRaise  <= st.addrOut;
      selOutDrop    <= st.selDrop;
      disconnectReq <= st.disconnect;
      selStart      <= st.selStart;
      selStatusOnly <= st.selStart && st.statusOnly;
    end
  end

  // R1
  store_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> (ccValid && ccCode == CC_STORED));

  // R1
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.clearPend && !pendSet && !st.setInt) |=> !pendValid);

  // R7
  disconnect_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    disconnectReq |-> (storeReq && storeStatus == '0));

  // R5
  halt_tags_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrOutRaise |-> (selOutDrop && ccValid && ccCode == CC_BUSY));

  // R3
  sel_no_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selStart, ccValid}));

endmodule

// File: rtl/io_cc_responder.sv
module io_cc_responder
  import io_cc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int STAT_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                instValid,
  input  logic [1:0]          instKind,
  input  logic [ADDR_W-1:0]   unitAddr,
  input  logic                pendSet,
  input  logic [ADDR_W-1:0]   pendSetAddr,
  input  logic [STAT_W-1:0]   pendSetStatus,
  input  logic                chanOper,
  input  logic                subAvail,
  input  logic                subWorking,
  input  logic                subBurst,
  input  logic                subIsSelector,
  input  logic                endIntOut,
  input  logic                anyIfAvail,
  input  logic                allIfBurst,
  input  logic                selDone,
  input  logic [1:0]          selResp,
  input  logic [STAT_W-1:0]   devStatus,
  input  logic [STAT_W-1:0]   chanStatIn,
  input  logic                statusAccepted,
  output logic                busy,
  output logic                ccValid,
  output logic [1:0]          ccCode,
  output logic                storeReq,
  output logic [2*STAT_W-1:0] storeStatus,
  output logic                intReqSet,
  output logic                addrOutRaise,
  output logic                selOutDrop,
  output logic                disconnectReq,
  output logic                selStart,
  output logic                selStatusOnly
);

  strobeT stb;
  logic   pendValid;
  logic   pendMatch;

  io_cc_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .instValid      (instValid),
    .instKind       (instKind),
    .chanOper       (chanOper),
    .subAvail       (subAvail),
    .subWorking     (subWorking),
    .subBurst       (subBurst),
    .subIsSelector  (subIsSelector),
    .endIntOut      (endIntOut),
    .anyIfAvail     (anyIfAvail),
    .allIfBurst     (allIfBurst),
    .selDone        (selDone),
    .selResp        (selResp),
    .devStatus      (devStatus),
    .statusAccepted (statusAccepted),
    .pendValid      (pendValid),
    .pendMatch      (pendMatch),
    .st             (stb),
    .busy           (busy)
  );

  io_cc_datapath #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .st            (stb),
    .unitAddr      (unitAddr),
    .pendSet       (pendSet),
    .pendSetAddr   (pendSetAddr),
    .pendSetStatus (pendSetStatus),
    .devStatus     (devStatus),
    .chanStatIn    (chanStatIn),
    .pendValid     (pendValid),
    .pendMatch     (pendMatch),
    .ccValid       (ccValid),
    .ccCode        (ccCode),
    .storeReq      (storeReq),
    .storeStatus   (storeStatus),
    .intReqSet     (intReqSet),
    .addrOutRaise  (addrOutRaise),
    .selOutDrop    (selOutDrop),
    .disconnectReq (disconnectReq),
    .selStart      (selStart),
    .selStatusOnly (selStatusOnly)
  );

endmodule

// File: tb/io_cc_responder_bench.sv
module io_cc_responder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [1:0]  instKind = 2'd3;
  logic [7:0]  unitAddr = '0;
  logic        pendSet = 1'b0;
  logic [7:0]  pendSetAddr = '0;
  logic [7:0]  pendSetStatus = '0;
  logic        chanOper = 1'b1;
  logic        subAvail = 1'b0, subWorking = 1'b0, subBurst = 1'b0;
  logic        subIsSelector = 1'b0, endIntOut = 1'b0;
  logic        anyIfAvail = 1'b0, allIfBurst = 1'b0;
  logic        selDone = 1'b0;
  logic [1:0]  selResp = 2'd0;
  logic [7:0]  devStatus = '0;
  logic [7:0]  chanStatIn = 8'hA5;
  logic        statusAccepted = 1'b0;
  logic        busy, ccValid, storeReq, intReqSet, addrOutRaise, selOutDrop;
  logic        disconnectReq, selStart, selStatusOnly;
  logic [1:0]  ccCode;
  logic [15:0] storeStatus;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  io_cc_responder u_io_cc_responder (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instKind(instKind),
    .unitAddr(unitAddr), .pendSet(pendSet), .pendSetAddr(pendSetAddr),
    .pendSetStatus(pendSetStatus), .chanOper(chanOper), .subAvail(subAvail),
    .subWorking(subWorking), .subBurst(subBurst), .subIsSelector(subIsSelector),
    .endIntOut(endIntOut), .anyIfAvail(anyIfAvail), .allIfBurst(allIfBurst),
    .selDone(selDone), .selResp(selResp), .devStatus(devStatus),
    .chanStatIn(chanStatIn), .statusAccepted(statusAccepted), .busy(busy),
    .ccValid(ccValid), .ccCode(ccCode), .storeReq(storeReq),
    .storeStatus(storeStatus), .intReqSet(intReqSet), .addrOutRaise(addrOutRaise),
    .selOutDrop(selOutDrop), .disconnectReq(disconnectReq), .selStart(selStart),
    .selStatusOnly(selStatusOnly)
  );

  // {kind[1:0], oper, avail, working, burst, isSel, endInt, anyIf, allBurst, cc[1:0], int, addrOut}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    14'b10_1000_0000_1100, // R8 not operational  -> 11 (first vector overwritten below)
    14'b10_1000_0010_0000, // R8 interface avail   -> 00
    14'b10_1000_0001_1000, // R8 all burst         -> 10
    14'b10_1000_0000_1100, // R8 nothing           -> 11
    14'b10_1000_0011_0000, // R8 avail beats burst -> 00
    14'b00_0100_0000_1100, // R9 test-I/O, channel down -> 11
    14'b00_1010_0000_1000, // R2 working -> 10
    14'b00_1001_0000_1000, // R2 burst   -> 10
    14'b00_1000_0000_1100, // test-I/O, not available -> 11
    14'b01_0100_0000_1100, // R9 halt, channel down -> 11
    14'b01_1010_1100_0000, // R4 selector end interrupt -> 00
    14'b01_1010_0000_0000, // R4 multiplex working -> 00
    14'b01_1000_1000_0000, // R4 selector idle unavailable -> 00
    14'b01_1010_1000_1011  // R5 selector working -> 10 + tags + interrupt
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] a);
    @(negedge clk);
    instValid = 1'b1; instKind = k; unitAddr = a;
    @(negedge clk);
    instValid = 1'b0; instKind = 2'd3;
  endtask

  task automatic reply(input logic [1:0] r, input logic [7:0] d);
    selDone = 1'b1; selResp = r; devStatus = d;
    @(negedge clk);
    selDone = 1'b0; devStatus = '0;
  endtask

  task automatic setState(input logic op, av, wk, bu, se, ei, ai, ab);
    chanOper = op; subAvail = av; subWorking = wk; subBurst = bu;
    subIsSelector = se; endIntOut = ei; anyIfAvail = ai; allIfBurst = ab;
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !ccValid && !storeReq && !intReqSet && !selStart && !addrOutRaise,
        "R11 reset outputs", {busy, ccValid, storeReq, intReqSet, selStart}, 0);
    rstN = 1'b1;
    @(negedge clk);
    setState(1, 0, 0, 0, 0, 0, 0, 1);
    issue(2'd2, 8'h00);
    chk(ccValid && ccCode == 2'b10, "R11 pending empty after reset", ccCode, 2'b10);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      setState(i == 0 ? 1'b0 : v[11], v[10], v[9], v[8], v[7], v[6], v[5], v[4]);
      issue(v[13:12], 8'h3C);
      // R12 release one cycle after the instruction edge
      chk(ccValid && ccCode == v[3:2], "R12/R8/R2/R4/R5/R9 vector code",
          {ccValid, ccCode}, {1'b1, v[3:2]});
      chk(intReqSet == v[1] && addrOutRaise == v[0] && selOutDrop == v[0],
          "R5 halt tags", {intReqSet, addrOutRaise, selOutDrop}, {v[1], v[0], v[0]});
      chk(!storeReq && !selStart, "R2 no store or selection", {storeReq, selStart}, 0);
    end

    // pending record at 0x3C from the working-selector halt
    setState(1, 0, 0, 0, 0, 0, 0, 1);
    issue(2'd2, 8'h00);
    chk(ccValid && ccCode == 2'b01, "R8 pending beats all-burst", ccCode, 2'b01);
    setState(1, 0, 1, 0, 0, 0, 0, 1);
    issue(2'd0, 8'h55);
    chk(ccValid && ccCode == 2'b10 && !storeReq, "R2 unmatched address busy", ccCode, 2'b10);
    issue(2'd0, 8'h3C);
    chk(ccValid && ccCode == 2'b01 && storeReq && storeStatus == 16'h00A5,
        "R1 matched pending store", storeStatus, 16'h00A5);
    setState(1, 0, 0, 0, 0, 0, 0, 1);
    issue(2'd2, 8'h00);
    chk(ccValid && ccCode == 2'b10, "R1 pending cleared", ccCode, 2'b10);

    // externally loaded record
    @(negedge clk);
    pendSet = 1'b1; pendSetAddr = 8'h11; pendSetStatus = 8'h42;
    @(negedge clk);
    pendSet = 1'b0;
    setState(1, 1, 0, 0, 0, 0, 0, 0);
    issue(2'd0, 8'h11);
    chk(ccValid && storeReq && storeStatus == 16'h42A5, "R1 loaded record store",
        storeStatus, 16'h42A5);

    // R3 test-I/O selection outcomes
    issue(2'd0, 8'h20);
    chk(selStart && selStatusOnly && busy && !ccValid, "R3 status-only select",
        {selStart, selStatusOnly, busy, ccValid}, 4'b1110);
    reply(2'd0, 8'h0C);
    chk(ccValid && ccCode == 2'b01 && storeStatus == 16'h0CA5, "R3 nonzero status",
        storeStatus, 16'h0CA5);
    issue(2'd0, 8'h20);
    // R10 instruction during selection wait is dropped
    issue(2'd2, 8'h00);
    chk(!ccValid && busy, "R10 dropped while busy", {ccValid, busy}, 2'b01);
    reply(2'd0, 8'h00);
    chk(ccValid && ccCode == 2'b00 && !storeReq, "R3 zero status", ccCode, 2'b00);
    @(negedge clk);
    chk(!ccValid && !busy, "R10 no queued release", {ccValid, busy}, 0);
    issue(2'd0, 8'h20);
    reply(2'd2, 8'h00);
    chk(ccValid && ccCode == 2'b11 && !storeReq, "R3 select-in", ccCode, 2'b11);

    // R7 halt to available subchannel
    issue(2'd1, 8'h21);
    chk(selStart && !selStatusOnly, "R7 halt select", {selStart, selStatusOnly}, 2'b10);
    reply(2'd0, 8'h99);
    chk(ccValid && ccCode == 2'b01 && disconnectReq && storeReq && storeStatus == 16'h0000,
        "R7 operational-in disconnect", storeStatus, 0);
    issue(2'd1, 8'h21);
    reply(2'd1, 8'h70);
    chk(ccValid && ccCode == 2'b01 && !disconnectReq && storeStatus == 16'h7000,
        "R7 control-unit busy", storeStatus, 16'h7000);
    issue(2'd1, 8'h21);
    reply(2'd2, 8'h00);
    chk(ccValid && ccCode == 2'b11 && !storeReq, "R7 select-in", ccCode, 2'b11);

    // R10 kind 3 gives no release
    issue(2'd3, 8'h21);
    chk(!ccValid && !busy, "R10 kind 3 ignored", {ccValid, busy}, 0);

    // R6 burst halt on multiplex subchannel
    setState(1, 0, 1, 1, 0, 0, 0, 1);
    issue(2'd1, 8'h77);
    chk(ccValid && ccCode == 2'b10 && addrOutRaise && selOutDrop && !intReqSet,
        "R6 burst halt release", {ccCode, intReqSet}, 3'b100);
    repeat (3) @(negedge clk);
    chk(busy && !intReqSet, "R6 interrupt deferred", {busy, intReqSet}, 2'b10);
    statusAccepted = 1'b1;
    @(negedge clk);
    statusAccepted = 1'b0;
    chk(intReqSet && !ccValid, "R6 interrupt after acceptance", intReqSet, 1);
    @(negedge clk);
    chk(!busy && !intReqSet, "R6 single pulse", {busy, intReqSet}, 0);
    setState(1, 0, 0, 0, 0, 0, 0, 1);
    issue(2'd2, 8'h00);
    chk(ccValid && ccCode == 2'b01, "R6 halted interrupt pending", ccCode, 2'b01);
    issue(2'd0, 8'h77);
    chk(storeReq && storeStatus == 16'h00A5, "R1 halted address match", storeStatus, 16'h00A5);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule